// File: doc/BRIEF.md
# I2C Master Byte Transmit Engine

This block sends one byte as an I2C bus master and then reads the acknowledge from the addressed slave. The byte may be an address with its read/write bit, or a data byte. The host loads the byte through a one-cycle write strobe. That write starts an internal bit-period counter. The block then clocks the eight bits out most-significant first, lets go of SDA for the ninth clock, and records whether the slave pulled SDA low.

Both bus lines are open-drain. The block only drives drive-low enables, and a released line is pulled high outside the block. Between bytes, SCL is held low and SDA is released. The engine waits in that state until the host writes the next byte. START, STOP and repeated-START conditions are produced elsewhere.

The host sees four flags:
- a buffer-full flag, set while the byte is still being shifted;
- an acknowledge-status flag;
- a sticky write-collision flag, set when a write arrives during a transfer;
- a sticky completion flag, used as the interrupt.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset, `scl_low` is 1 and `sda_low` is 0. `buf_full`, `ack_stat`, `wcol` and `done_irq` are all 0.
- R2: A write accepted while the engine is idle sets `buf_full` on the next clock. The byte is sent MSB first, with `sda_low` = 1 for a 0 bit and 0 for a 1 bit. `sda_low` never changes while SCL is released.
- R3: Each SCL low phase and each SCL high phase lasts `brg_reload`+1 clock cycles. `done_irq` rises 18×(`brg_reload`+1) cycles after the clock edge that takes the write.
- R4: `buf_full` clears at the eighth SCL falling edge. At that same edge SDA is released (`sda_low` = 0) for the ninth bit.
- R5: SDA is sampled at the end of the ninth SCL high phase. `ack_stat` becomes 0 if SDA is low there and 1 if SDA is high. It keeps that value until the end of the next byte.
- R6: After the ninth clock, `done_irq` is set, SCL is held low and SDA is released. No further SCL edge occurs until the next write.
- R7: A write that arrives while a byte is in progress, up to and including the ninth clock, sets `wcol`. It changes neither the bits on the bus nor the transfer timing.
- R8: `wcol` stays set until a `clr_wcol` strobe. A collision in the same cycle as the clear leaves `wcol` set.
- R9: `done_irq` stays set until a `clr_done` strobe.
- R10: `brg_reload` is captured when a write is taken. Changing it during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle buffer write strobe |
| wr_data | input | 8 | Byte to send |
| brg_reload | input | BRG_W | Bit-period reload value; each phase lasts this value plus one cycle |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_done | input | 1 | Clears the completion flag |
| sda_in | input | 1 | Level of the SDA line |
| scl_low | output | 1 | Drive-low enable for SCL |
| sda_low | output | 1 | Drive-low enable for SDA |
| buf_full | output | 1 | Byte still being shifted |
| ack_stat | output | 1 | 1 if the last byte was not acknowledged |
| wcol | output | 1 | Sticky write-collision flag |
| done_irq | output | 1 | Sticky completion flag |

## Verification
Let P be `brg_reload`+1 and take the write-accepting edge as edge 0.
- `buf_full` is due one cycle after the write, at edge 0.
- Every SCL phase is due P cycles after the previous one.
- `buf_full` clears at edge 16P.
- `ack_stat` and `done_irq` change together at edge 18P.
- `wcol` changes on the edge that samples the colliding write.

The bench drives inputs and samples outputs on falling clock edges, counting one per cycle after the write. A bus monitor measures each SCL phase length against P and captures the bit on SDA at every SCL rise. It also records `buf_full` and SDA exactly at the eighth rise and the eighth fall, so each result is compared in the cycle it is due.

// File: rtl/i2c_byte_tx_pkg.sv
package i2c_byte_tx_pkg;

  // Sequencer phase: waiting, SCL driven low, SCL released
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/i2c_byte_tx_brg.sv
// Bit-period counter: reload captured at start, one tick per phase.
module i2c_byte_tx_brg #(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [BRG_W-1:0] reload,
  output logic             tick
);

  logic [BRG_W-1:0] cnt_q, cnt_d;
  logic [BRG_W-1:0] rld_q, rld_d;

  always_comb begin
    cnt_d = cnt_q;
    rld_d = rld_q;
    if (start) begin
      rld_d = reload;
      cnt_d = reload;
    end else if (run) begin
      if (cnt_q == '0) cnt_d = rld_q;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign tick = run && !start && (cnt_q == '0);

  // R3: count never leaves the captured range while running
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= rld_q));

  // R10: the captured reload only changes on a start
  p_reload_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(rld_q));

endmodule

// File: rtl/i2c_byte_tx_seq.sv
// Bit sequencer: shifts the byte, releases SDA for the ninth clock, samples ack.
module i2c_byte_tx_seq
  import i2c_byte_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [BITS-1:0] data,
  input  logic            tick,
  input  logic            sda_in,
  output logic            busy,
  output logic            scl_low,
  output logic            sda_low,
  output logic            byte_out,
  output logic            finish,
  output logic            nack
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BITS - 1);

  phase_e          ph_q, ph_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [BITS-1:0]  sh_q, sh_d;
  logic             scl_q, scl_d;
  logic             sda_q, sda_d;

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    scl_d    = scl_q;
    sda_d    = sda_q;
    byte_out = 1'b0;
    finish   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        scl_d = 1'b1;
        sda_d = 1'b0;
        if (start) begin
          ph_d  = PH_LOW;
          idx_d = '0;
          sh_d  = data;
          sda_d = ~data[BITS-1];
        end
      end
      PH_LOW: begin
        if (tick) begin
          ph_d  = PH_HIGH;
          scl_d = 1'b0;
        end
      end
      PH_HIGH: begin
        if (tick) begin
          scl_d = 1'b1;
          if (idx_q == ACK_IDX) begin
            ph_d   = PH_IDLE;
            sda_d  = 1'b0;
            finish = 1'b1;
          end else begin
            ph_d  = PH_LOW;
            idx_d = idx_q + 1'b1;
            sh_d  = {sh_q[BITS-2:0], 1'b0};
            if (idx_q == LAST_IDX) begin
              sda_d    = 1'b0;
              byte_out = 1'b1;
            end else begin
              sda_d = ~sh_q[BITS-2];
            end
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      idx_q <= '0;
      sh_q  <= '0;
      scl_q <= 1'b1;
      sda_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign busy    = (ph_q != PH_IDLE);
  assign scl_low = scl_q;
  assign sda_low = sda_q;
  assign nack    = finish & sda_in;

  // R2: data only moves while SCL is held low
  p_sda_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && !$past(scl_q)) |-> (sda_q == $past(sda_q)));

  // R4: master lets go of SDA during the acknowledge clock
  p_ack_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx_q == ACK_IDX) |-> !sda_q);

  // R6: idle parks SCL low with SDA floating
  p_idle_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (scl_q && !sda_q));

  // R6: SCL is never released while idle
  p_no_idle_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !start) |=> scl_q);

endmodule

// File: rtl/i2c_byte_tx_flags.sv
// Host-visible status flags.
module i2c_byte_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic collide,
  input  logic byte_out,
  input  logic finish,
  input  logic nack,
  input  logic clr_wcol,
  input  logic clr_done,
  output logic buf_full,
  output logic ack_stat,
  output logic wcol,
  output logic done_irq
);

  logic bf_q, bf_d;
  logic ak_q, ak_d;
  logic wc_q, wc_d;
  logic dn_q, dn_d;

  always_comb begin
    bf_d = bf_q;
    if (accept)        bf_d = 1'b1;
    else if (byte_out) bf_d = 1'b0;

    ak_d = ak_q;
    if (finish) ak_d = nack;

    // set takes priority over the clear strobe
    wc_d = wc_q;
    if (collide)       wc_d = 1'b1;
    else if (clr_wcol) wc_d = 1'b0;

    dn_d = dn_q;
    if (finish)        dn_d = 1'b1;
    else if (clr_done) dn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bf_q <= 1'b0;
      ak_q <= 1'b0;
      wc_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      bf_q <= bf_d;
      ak_q <= ak_d;
      wc_q <= wc_d;
      dn_q <= dn_d;
    end
  end

  assign buf_full = bf_q;
  assign ack_stat = ak_q;
  assign wcol     = wc_q;
  assign done_irq = dn_q;

  // R7: a collision always shows up next cycle
  p_collide_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> wc_q);

  // R8: wcol only falls through the clear strobe
  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wc_q && !clr_wcol) |=> wc_q);

  // R9: done only falls through the clear strobe
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_q && !clr_done) |=> dn_q);

  // R2: accepted write raises buffer-full
  p_accept_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> bf_q);

endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
  import i2c_byte_tx_pkg::*;
#(
  parameter int BRG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             clr_wcol,
  input  logic             clr_done,
  input  logic             sda_in,
  output logic             scl_low,
  output logic             sda_low,
  output logic             buf_full,
  output logic             ack_stat,
  output logic             wcol,
  output logic             done_irq
);

  localparam int BITS = 8;

  logic busy, accept, collide, tick, byte_out, finish, nack;

  assign accept  = wr_en && !busy;
  assign collide = wr_en &&  busy;

  i2c_byte_tx_brg #(.BRG_W(BRG_W)) u_brg (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (busy),
    .reload (brg_reload),
    .tick   (tick)
  );

  i2c_byte_tx_seq #(.BITS(BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .data     (wr_data),
    .tick     (tick),
    .sda_in   (sda_in),
    .busy     (busy),
    .scl_low  (scl_low),
    .sda_low  (sda_low),
    .byte_out (byte_out),
    .finish   (finish),
    .nack     (nack)
  );

  i2c_byte_tx_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .collide  (collide),
    .byte_out (byte_out),
    .finish   (finish),
    .nack     (nack),
    .clr_wcol (clr_wcol),
    .clr_done (clr_done),
    .buf_full (buf_full),
    .ack_stat (ack_stat),
    .wcol     (wcol),
    .done_irq (done_irq)
  );

  // R4: no byte pending once the engine is idle
  p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buf_full);

  // R7: a busy write leaves the shifted contents alone (no restart)
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !finish) |=> busy);

endmodule

// File: tb/i2c_byte_tx_test.sv
module i2c_byte_tx_test;

  localparam int CLK_PERIOD = 10;

  // {data[17:10], reload[9:2], slave_acks[1], exp_ack_stat[0]}
  localparam logic [17:0] VEC [0:4] = '{
    {8'hA5, 8'd3, 1'b1, 1'b0},
    {8'h3C, 8'd0, 1'b0, 1'b1},
    {8'hFF, 8'd1, 1'b1, 1'b0},
    {8'h00, 8'd2, 1'b0, 1'b1},
    {8'h81, 8'd5, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] brg_reload = '0;
  logic       clr_wcol = 1'b0;
  logic       clr_done = 1'b0;
  logic       scl_low, sda_low, buf_full, ack_stat, wcol, done_irq;

  logic slave_pull = 1'b0;
  logic slave_ack_en = 1'b0;
  wire  sda_line = ~sda_low & ~slave_pull;
  wire  scl_line = ~scl_low;

  int checks = 0;
  int failures = 0;
  int cur_period = 1;
  bit finished = 0;

  // monitor state (written only by the monitor)
  int   rises = 0;
  int   phase_len = 0;
  int   phase_err = 0;
  int   sda_err = 0;
  logic [7:0] cap = '0;
  logic scl_prev = 1'b0;
  logic sda_prev = 1'b0;
  logic bf_prev = 1'b0;
  logic bf_rise8 = 1'b0;
  logic bf_fall8 = 1'b1;
  logic sda_fall8 = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .brg_reload(brg_reload), .clr_wcol(clr_wcol), .clr_done(clr_done),
    .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low),
    .buf_full(buf_full), .ack_stat(ack_stat), .wcol(wcol), .done_irq(done_irq)
  );

  // Bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_full && !bf_prev) begin
        rises = 0; cap = '0; phase_len = 0;
      end
      if (scl_line != scl_prev) begin
        if (scl_prev || rises >= 1) begin
          if (phase_len != cur_period) phase_err = phase_err + 1;
        end
        phase_len = 1;
        if (scl_line) begin
          rises = rises + 1;
          if (rises <= 8) cap = {cap[6:0], sda_line};
          if (rises == 8) bf_rise8 = buf_full;
        end else if (rises == 8) begin
          bf_fall8  = buf_full;
          sda_fall8 = sda_low;
        end
      end else begin
        phase_len = phase_len + 1;
        if (scl_line && sda_low != sda_prev) sda_err = sda_err + 1;
      end
      slave_pull = slave_ack_en && ((rises == 8 && !scl_line) || rises == 9);
      scl_prev = scl_line;
      sda_prev = sda_low;
      bf_prev  = buf_full;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, input logic [7:0] rl, input bit ack,
                      input int coll_at, input int chg_at, output int cyc);
    int n;
    @(negedge clk) clr_done = 1'b1;
    @(negedge clk) clr_done = 1'b0;
    slave_ack_en = ack;
    cur_period = int'(rl) + 1;
    @(negedge clk);
    wr_data = d; brg_reload = rl; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    n = 0;
    while (!done_irq && n < 5000) begin
      if (n == coll_at) begin wr_en = 1'b1; wr_data = ~d; end
      else wr_en = 1'b0;
      if (n == chg_at) brg_reload = ~rl;
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0;
    brg_reload = rl;
    slave_ack_en = 1'b0;
    cyc = n;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, pe0, se0, p;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 scl_low", scl_low, 1);
    chk("R1 sda_low", sda_low, 0);
    chk("R1 flags", {buf_full, ack_stat, wcol, done_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 buf_full one cycle after write
    @(negedge clk) begin wr_data = 8'h96; brg_reload = 8'd2; wr_en = 1'b1; cur_period = 3; end
    @(negedge clk) wr_en = 1'b0;
    chk("R2 buf_full after write", buf_full, 1);
    chk("R2 first bit on SDA", sda_low, 0);
    while (!done_irq) @(negedge clk);

    // vector table
    for (int i = 0; i < 5; i++) begin
      pe0 = phase_err; se0 = sda_err;
      p = int'(VEC[i][9:2]) + 1;
      xfer(VEC[i][17:10], VEC[i][9:2], VEC[i][1], -1, -1, cyc);
      chk("R3 done cycle", cyc, 18 * p);
      chk("R3 phase lengths", phase_err - pe0, 0);
      chk("R2 byte on bus", cap, VEC[i][17:10]);
      chk("R2 sda steady while high", sda_err - se0, 0);
      chk("R4 bf at 8th rise", bf_rise8, 1);
      chk("R4 bf at 8th fall", bf_fall8, 0);
      chk("R4 sda released at 8th fall", sda_fall8, 0);
      chk("R5 ack_stat", ack_stat, VEC[i][0]);
      chk("R6 parked lines", {scl_low, sda_low}, 2'b10);
      chk("R6 nine clocks", rises, 9);
      chk("R7 no wcol", wcol, 0);
    end

    // R6 / R9: stays parked, done sticky
    repeat (12) @(negedge clk);
    chk("R6 no extra clocks", rises, 9);
    chk("R6 scl held low", scl_low, 1);
    chk("R9 done sticky", done_irq, 1);
    chk("R5 ack_stat held", ack_stat, 0);
    @(negedge clk) clr_done = 1'b1;
    @(negedge clk) clr_done = 1'b0;
    chk("R9 done cleared", done_irq, 0);

    // R7 collision mid byte
    pe0 = phase_err;
    xfer(8'h5A, 8'd2, 1'b0, 20, -1, cyc);
    chk("R7 wcol set", wcol, 1);
    chk("R7 byte unchanged", cap, 8'h5A);
    chk("R7 timing unchanged", cyc, 54);
    chk("R7 phases unchanged", phase_err - pe0, 0);
    chk("R5 nack", ack_stat, 1);
    repeat (5) @(negedge clk);
    chk("R8 wcol sticky", wcol, 1);
    @(negedge clk) clr_wcol = 1'b1;
    @(negedge clk) clr_wcol = 1'b0;
    chk("R8 wcol cleared", wcol, 0);

    // R7 collision during ninth clock
    xfer(8'hC3, 8'd1, 1'b1, 17 * 2 - 1, -1, cyc);
    chk("R7 wcol in ack clock", wcol, 1);
    chk("R7 byte unchanged ack", cap, 8'hC3);
    chk("R7 timing ack", cyc, 36);
    chk("R5 ack", ack_stat, 0);

    // R8 collide and clear in same cycle
    @(negedge clk) clr_wcol = 1'b1;
    @(negedge clk) clr_wcol = 1'b0;
    chk("R8 clear before test", wcol, 0);
    @(negedge clk) clr_done = 1'b1;
    @(negedge clk) clr_done = 1'b0;
    @(negedge clk) begin wr_data = 8'h11; brg_reload = 8'd1; wr_en = 1'b1; cur_period = 2; end
    @(negedge clk) begin wr_data = 8'hEE; wr_en = 1'b1; clr_wcol = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; clr_wcol = 1'b0; end
    chk("R8 set beats clear", wcol, 1);
    while (!done_irq) @(negedge clk);
    chk("R7 byte kept", cap, 8'h11);
    @(negedge clk) clr_wcol = 1'b1;
    @(negedge clk) clr_wcol = 1'b0;

    // R10 reload change mid transfer
    pe0 = phase_err;
    xfer(8'h6B, 8'd4, 1'b1, -1, 7, cyc);
    chk("R10 timing from captured reload", cyc, 90);
    chk("R10 phases", phase_err - pe0, 0);
    chk("R10 byte", cap, 8'h6B);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule